// File: doc/BRIEF.md
# Bidirectional Dual-FIFO Port Controller

This block joins two data ports through a pair of queues that run in opposite directions. The forward queue takes words written on port A and hands them out on port B. The return queue takes words written on port B and hands them out on port A. Each queue holds 512 words of 36 bits. Both ports run on one shared clock.

On each port, a single shared bus is modelled as an input word, an output word and an output-enable. The output-enable tells the pad ring when the block drives the bus. On every rising edge, each port decides from four controls whether it writes, reads or does nothing: an active-low chip select, a direction pin, an enable and a mailbox select. Port B's direction pin has the opposite sense from port A's.

Each port shows an input-ready flag for the queue it writes and an output-ready flag for the queue it reads. After a master reset, both queues are empty. Neither input-ready flag rises until the external configuration-done input has been seen.

Top module: `bidir_fifo_ctrl`

## Requirements
- R1: `a_oe` is high exactly when `a_cs_n` is 0 and `a_wr` is 0 (port A reading). In every other case port A's bus is released.
- R2: `b_oe` is high exactly when `b_cs_n` is 0 and `b_rd` is 1 (port B reading). In every other case port B's bus is released.
- R3: A rising edge writes `a_din` into the forward queue when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbox`=0 and `a_ir`=1.
- R4: A rising edge reads the return queue when `a_cs_n`=0, `a_wr`=0, `a_en`=1, `a_mbox`=0 and `a_or`=1. The word appears on `a_dout` after that edge and holds until the next port A read. Words leave in the order they were written.
- R5: A rising edge writes `b_din` into the return queue when `b_cs_n`=0, `b_rd`=0, `b_en`=1, `b_mbox`=0 and `b_ir`=1.
- R6: A rising edge reads the forward queue onto `b_dout` when `b_cs_n`=0, `b_rd`=1, `b_en`=1, `b_mbox`=0 and `b_or`=1. The output then holds until the next port B read.
- R7: While a port's mailbox select is 1, that port neither writes nor reads a queue.
- R8: Each queue holds exactly 512 words. After the 512th write, the writer's input-ready flag is 0, and further writes are ignored.
- R9: A write and a read of the same queue in one cycle leave its word count unchanged. A read of an empty queue is never performed, even if a write lands on the same edge.
- R10: Master reset (`rst_n`=0) empties both queues and clears both output registers to 0. After reset, both input-ready flags stay 0 until `cfg_done` has been 1 on at least one rising edge, and both output-ready flags are 0.
- R11: Accesses on port A do not depend on what port B does in the same cycle, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Master reset, active low |
| cfg_done | input | 1 | Flag-offset setup finished; arms the input-ready flags |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A access enable |
| a_mbox | input | 1 | Port A mailbox select; 1 blocks queue access |
| a_din | input | 36 | Port A bus, inbound word |
| a_dout | output | 36 | Port A bus, outbound word |
| a_oe | output | 1 | Port A bus drive enable |
| a_ir | output | 1 | Forward queue input-ready |
| a_or | output | 1 | Return queue output-ready |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_rd | input | 1 | Port B direction: 1 read, 0 write |
| b_en | input | 1 | Port B access enable |
| b_mbox | input | 1 | Port B mailbox select; 1 blocks queue access |
| b_din | input | 36 | Port B bus, inbound word |
| b_dout | output | 36 | Port B bus, outbound word |
| b_oe | output | 1 | Port B bus drive enable |
| b_ir | output | 1 | Return queue input-ready |
| b_or | output | 1 | Forward queue output-ready |

## Verification
The bench targets four corner cases, each of which a faulty design would reveal:
- **Direction polarity.** The bench drives the same direction level on both ports. A design that copied port A's polarity to port B would then write where it should read, and would assert the wrong output-enable.
- **Full queue.** The bench fills the forward queue to exactly 512 words and keeps writing. A design with an off-by-one bound would either drop the last word or overwrite the oldest one. Either fault shows up when the queue is drained and its contents are compared.
- **Simultaneous read and write.** The bench writes and reads a queue on the same edge, both when the queue is full and when it is part full. It also writes into an empty queue while a read is requested on the same edge. A design that miscounted would lose or duplicate a word, or would deliver stale data.
- **Reset and mailbox gating.** Writes are attempted before `cfg_done` and with the mailbox select raised. A design that let these writes through would show output-ready going high.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    // which level of the direction pin selects a read
    typedef enum logic {
        RD_ON_LOW  = 1'b0,
        RD_ON_HIGH = 1'b1
    } rd_pol_e;

    // per-port decision for one clock edge
    typedef struct packed {
        logic wr_go;
        logic rd_go;
        logic oe;
    } port_cmd_t;

endpackage

// File: rtl/bfc_port_decode.sv
module bfc_port_decode
    import bfc_pkg::*;
#(
    parameter rd_pol_e RD_POL = RD_ON_LOW
) (
    input  logic      cs_n,
    input  logic      dir,
    input  logic      en,
    input  logic      mbox,
    input  logic      room,
    input  logic      avail,
    output port_cmd_t cmd
);

    logic rd_sel;
    logic access;

    generate
        if (RD_POL == RD_ON_HIGH) begin : g_rd_high
            assign rd_sel = dir;
        end else begin : g_rd_low
            assign rd_sel = ~dir;
        end
    endgenerate

    // the mailbox select steals the whole access (R7)
    assign access = ~cs_n & en & ~mbox;

    always_comb begin
        cmd.wr_go = access & ~rd_sel & room;
        cmd.rd_go = access &  rd_sel & avail;
        cmd.oe    = ~cs_n & rd_sel;
    end

endmodule

// File: rtl/bfc_fifo.sv
module bfc_fifo #(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] dout;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            st_d.wp = (st_q.wp == LAST_ADDR) ? '0 : st_q.wp + 1'b1;
        end
        if (rd_go) begin
            st_d.rp   = (st_q.rp == LAST_ADDR) ? '0 : st_q.rp + 1'b1;
            st_d.dout = mem[st_q.rp];
        end
        case ({wr_go, rd_go})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[st_q.wp] <= wr_data;
        end
    end

    assign rd_data = st_q.dout;
    assign full    = (st_q.cnt == FULL_CNT);
    assign empty   = (st_q.cnt == '0);

endmodule

// File: rtl/bidir_fifo_ctrl.sv
module bidir_fifo_ctrl
    import bfc_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbox,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_oe,
    output logic              a_ir,
    output logic              a_or,
    input  logic              b_cs_n,
    input  logic              b_rd,
    input  logic              b_en,
    input  logic              b_mbox,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_oe,
    output logic              b_ir,
    output logic              b_or
);

    typedef struct packed {
        logic armed;
    } top_st_t;

    top_st_t   st_d, st_q;
    port_cmd_t cmd_a, cmd_b;
    logic      fwd_full, fwd_empty, ret_full, ret_empty;

    // sticky arm: once configuration is done, stays until master reset
    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | cfg_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_ir = st_q.armed & ~fwd_full;
    assign b_ir = st_q.armed & ~ret_full;
    assign a_or = ~ret_empty;
    assign b_or = ~fwd_empty;

    // port A: direction pin low means read
    bfc_port_decode #(.RD_POL(RD_ON_LOW)) u_dec_a (
        .cs_n  (a_cs_n),
        .dir   (a_wr),
        .en    (a_en),
        .mbox  (a_mbox),
        .room  (a_ir),
        .avail (a_or),
        .cmd   (cmd_a)
    );

    // port B: direction pin high means read
    bfc_port_decode #(.RD_POL(RD_ON_HIGH)) u_dec_b (
        .cs_n  (b_cs_n),
        .dir   (b_rd),
        .en    (b_en),
        .mbox  (b_mbox),
        .room  (b_ir),
        .avail (b_or),
        .cmd   (cmd_b)
    );

    bfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (cmd_a.wr_go),
        .wr_data (a_din),
        .rd_go   (cmd_b.rd_go),
        .rd_data (b_dout),
        .full    (fwd_full),
        .empty   (fwd_empty)
    );

    bfc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (cmd_b.wr_go),
        .wr_data (b_din),
        .rd_go   (cmd_a.rd_go),
        .rd_data (a_dout),
        .full    (ret_full),
        .empty   (ret_empty)
    );

    assign a_oe = cmd_a.oe;
    assign b_oe = cmd_b.oe;

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_cs_n,
    input logic              a_wr,
    input logic              a_en,
    input logic              a_mbox,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_oe,
    input logic              a_ir,
    input logic              a_or,
    input logic              b_cs_n,
    input logic              b_rd,
    input logic              b_en,
    input logic              b_mbox,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_oe,
    input logic              b_ir,
    input logic              b_or
);

    assert_a_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe |-> (!a_cs_n && !a_wr));

    assert_b_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe |-> (!b_cs_n && b_rd));

    // forward queue only gains data from a qualified port A write (R3, R7)
    assert_fwd_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_or) |-> $past(!a_cs_n && a_wr && a_en && !a_mbox && a_ir));

    // return queue only gains data from a qualified port B write (R5, R7)
    assert_ret_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_or) |-> $past(!b_cs_n && !b_rd && b_en && !b_mbox && b_ir));

    // port A output word moves only after a qualified port A read
    assert_a_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!a_cs_n && !a_wr && a_en && !a_mbox && a_or) |-> $stable(a_dout));

    // port B output word moves only after a qualified port B read
    assert_b_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!b_cs_n && b_rd && b_en && !b_mbox && b_or) |-> $stable(b_dout));

    // a queue can only become full through a write on its writer port (R8)
    assert_fwd_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_ir) |-> $past(!a_cs_n && a_wr && a_en && !a_mbox));

    assert_ret_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_ir) |-> $past(!b_cs_n && !b_rd && b_en && !b_mbox));

    // first edge after reset release still shows the cleared state (R10)
    assert_reset_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!a_ir && !b_ir && !a_or && !b_or));

endmodule

bind bidir_fifo_ctrl bfc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_cs_n (a_cs_n),
    .a_wr   (a_wr),
    .a_en   (a_en),
    .a_mbox (a_mbox),
    .a_dout (a_dout),
    .a_oe   (a_oe),
    .a_ir   (a_ir),
    .a_or   (a_or),
    .b_cs_n (b_cs_n),
    .b_rd   (b_rd),
    .b_en   (b_en),
    .b_mbox (b_mbox),
    .b_dout (b_dout),
    .b_oe   (b_oe),
    .b_ir   (b_ir),
    .b_or   (b_or)
);

// File: tb/bidir_fifo_ctrl_bench.sv
module bidir_fifo_ctrl_bench;

    localparam int DW    = 36;
    localparam int DEPTH = 512;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_done;
    logic          a_cs_n, a_wr, a_en, a_mbox;
    logic [DW-1:0] a_din;
    logic [DW-1:0] a_dout;
    logic          a_oe, a_ir, a_or;
    logic          b_cs_n, b_rd, b_en, b_mbox;
    logic [DW-1:0] b_din;
    logic [DW-1:0] b_dout;
    logic          b_oe, b_ir, b_or;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bidir_fifo_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) u_bidir_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
        .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbox(a_mbox),
        .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe), .a_ir(a_ir), .a_or(a_or),
        .b_cs_n(b_cs_n), .b_rd(b_rd), .b_en(b_en), .b_mbox(b_mbox),
        .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe), .b_ir(b_ir), .b_or(b_or)
    );

    typedef struct packed {
        logic          a_cs_n, a_wr, a_en, a_mbox;
        logic [DW-1:0] a_din;
        logic          b_cs_n, b_rd, b_en, b_mbox;
        logic [DW-1:0] b_din;
        logic          x_a_or, x_b_or, x_a_oe, x_b_oe;
        logic [DW-1:0] x_a_dout, x_b_dout;
    } vec_t;

    localparam int NV = 8;
    // starts with both queues empty and input-ready armed
    localparam vec_t VECS [NV] = '{
        // R3: A writes 111, B idle
        '{1'b0,1'b1,1'b1,1'b0, 36'h111, 1'b1,1'b0,1'b0,1'b0, 36'h0,   1'b0,1'b1,1'b0,1'b0, 36'h0,   36'h0},
        // R3 R5 R11: both ports write at once
        '{1'b0,1'b1,1'b1,1'b0, 36'h222, 1'b0,1'b0,1'b1,1'b0, 36'hAAA, 1'b1,1'b1,1'b0,1'b0, 36'h0,   36'h0},
        // R6 R2: B reads 111
        '{1'b1,1'b0,1'b0,1'b0, 36'h0,   1'b0,1'b1,1'b1,1'b0, 36'h0,   1'b1,1'b1,1'b0,1'b1, 36'h0,   36'h111},
        // R4 R6 R1 R11: both ports read at once
        '{1'b0,1'b0,1'b1,1'b0, 36'h0,   1'b0,1'b1,1'b1,1'b0, 36'h0,   1'b0,1'b0,1'b1,1'b1, 36'hAAA, 36'h222},
        // R7: A write with mailbox high is dropped
        '{1'b0,1'b1,1'b1,1'b1, 36'h555, 1'b1,1'b0,1'b0,1'b0, 36'h0,   1'b0,1'b0,1'b0,1'b0, 36'hAAA, 36'h222},
        // R3: A write with enable low is dropped
        '{1'b0,1'b1,1'b0,1'b0, 36'h666, 1'b1,1'b0,1'b0,1'b0, 36'h0,   1'b0,1'b0,1'b0,1'b0, 36'hAAA, 36'h222},
        // R6 R7: B reads empty queue, A mailbox read -> outputs hold
        '{1'b0,1'b0,1'b1,1'b1, 36'h0,   1'b0,1'b1,1'b1,1'b0, 36'h0,   1'b0,1'b0,1'b1,1'b1, 36'hAAA, 36'h222},
        // R9: write into empty queue while B reads it: read not taken
        '{1'b0,1'b1,1'b1,1'b0, 36'h333, 1'b0,1'b1,1'b1,1'b0, 36'h0,   1'b0,1'b1,1'b0,1'b1, 36'hAAA, 36'h222}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mbox = 1'b0; a_din = '0;
        b_cs_n = 1'b1; b_rd = 1'b0; b_en = 1'b0; b_mbox = 1'b0; b_din = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic a_write(input logic [DW-1:0] d);
        a_cs_n = 1'b0; a_wr = 1'b1; a_en = 1'b1; a_mbox = 1'b0; a_din = d;
    endtask

    task automatic b_read();
        b_cs_n = 1'b0; b_rd = 1'b1; b_en = 1'b1; b_mbox = 1'b0;
    endtask

    task automatic b_write(input logic [DW-1:0] d);
        b_cs_n = 1'b0; b_rd = 1'b0; b_en = 1'b1; b_mbox = 1'b0; b_din = d;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        cfg_done = 1'b0;
        repeat (3) @(negedge clk);

        // R10: reset state
        chk({a_ir, b_ir, a_or, b_or} == 4'b0, "R10 flags in reset", {a_ir, b_ir, a_or, b_or}, 0);
        chk(a_dout == '0 && b_dout == '0, "R10 outputs in reset", {a_dout, b_dout}, 0);

        rst_n = 1'b1;
        tick();
        chk({a_ir, b_ir} == 2'b00, "R10 not armed before cfg_done", {a_ir, b_ir}, 0);

        // R10: write before arming is refused
        a_write(36'h999);
        tick();
        chk(b_or == 1'b0, "R10 write refused before cfg_done", b_or, 0);
        idle();

        cfg_done = 1'b1;
        tick();
        cfg_done = 1'b0;
        tick();
        chk({a_ir, b_ir} == 2'b11, "R10 armed after cfg_done", {a_ir, b_ir}, 2'b11);

        // vector table
        for (int i = 0; i < NV; i++) begin
            a_cs_n = VECS[i].a_cs_n; a_wr = VECS[i].a_wr; a_en = VECS[i].a_en;
            a_mbox = VECS[i].a_mbox; a_din = VECS[i].a_din;
            b_cs_n = VECS[i].b_cs_n; b_rd = VECS[i].b_rd; b_en = VECS[i].b_en;
            b_mbox = VECS[i].b_mbox; b_din = VECS[i].b_din;
            tick();
            chk({a_or, b_or, a_oe, b_oe, a_dout, b_dout} ==
                {VECS[i].x_a_or, VECS[i].x_b_or, VECS[i].x_a_oe, VECS[i].x_b_oe,
                 VECS[i].x_a_dout, VECS[i].x_b_dout},
                $sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7 R9 R11)", i),
                {a_or, b_or, a_oe, b_oe, a_dout, b_dout},
                {VECS[i].x_a_or, VECS[i].x_b_or, VECS[i].x_a_oe, VECS[i].x_b_oe,
                 VECS[i].x_a_dout, VECS[i].x_b_dout});
        end

        // empty the forward queue (holds 333)
        idle();
        b_read();
        tick();
        chk(b_dout == 36'h333 && !b_or, "R6 drain single word", b_dout, 36'h333);
        idle();

        // R8: fill forward queue to capacity
        for (int i = 0; i < DEPTH; i++) begin
            a_write(DW'(i));
            tick();
        end
        chk(a_ir == 1'b0 && b_or == 1'b1, "R8 full after 512 writes", {a_ir, b_or}, 2'b01);
        a_write(36'hDEAD);
        tick();
        chk(a_ir == 1'b0, "R8 extra write ignored", a_ir, 0);

        // R9: full queue, write blocked while read proceeds
        a_write(36'hBEEF);
        b_read();
        tick();
        chk(b_dout == 36'd0 && a_ir == 1'b1, "R9 read on full with blocked write",
            {b_dout, a_ir}, {36'd0, 1'b1});

        // R9: part-full queue, simultaneous write and read
        for (int k = 0; k < 5; k++) begin
            a_write(DW'(1000 + k));
            b_read();
            tick();
            chk(b_dout == DW'(1 + k) && a_ir == 1'b1, "R9 simultaneous access",
                b_dout, DW'(1 + k));
        end
        idle();

        // R4 R8 R9: drain and verify order and count (506 old + 5 new)
        begin
            int n = 0;
            b_read();
            while (b_or && n < 600) begin
                tick();
                chk(b_dout == ((n < 506) ? DW'(6 + n) : DW'(1000 + n - 506)),
                    "R8 drain order", b_dout,
                    (n < 506) ? DW'(6 + n) : DW'(1000 + n - 506));
                n++;
            end
            chk(n == 511, "R9 word count kept", n, 511);
        end
        idle();

        // R5 R10: load return queue then master reset mid-operation
        b_write(36'h77);
        tick();
        b_write(36'h78);
        tick();
        idle();
        chk(a_or == 1'b1, "R5 return queue filled", a_or, 1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk({a_or, b_or, a_ir, b_ir} == 4'b0, "R10 reset clears queues and arm",
            {a_or, b_or, a_ir, b_ir}, 0);
        chk(a_dout == '0, "R10 output cleared", a_dout, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule